// File: doc/BRIEF.md
# Class-of-Service Cache Mask Table

This block stores the way-enable capacity masks of a shared cache, one mask for each implemented class of service (COS). Software programs the masks with register-style writes: the address is a fixed base (0xD10 by default) plus the COS index. Each hardware thread has an association register that names its COS, and the operating system rewrites it on a context switch. The block keeps a registered lookup of the mask that belongs to the currently running thread, and the cache's allocation logic applies that mask.

The block accepts a mask write only if the mask is a single unbroken run of ones. Rejected writes and writes outside the table's address window change nothing and raise a one-cycle error pulse. A thread may hold a COS that is larger than this table implements, because a sibling table for another cache level may implement more classes. For such a COS the block returns a fully open mask. The registered COS is also driven out so that the sibling table can index its own masks in step with this one.

Top module: `cosMaskTable`

## Requirements
- R1: On reset every stored mask becomes all ones, every thread's COS becomes 0, `lookupMask` reads all ones, `lookupCos` reads 0 and `wrErr` is low.
- R2: A write with `wrEn` high, `wrAddr` = BASE_ADDR + n (n < NUM_COS, so 0xD10..0xD13 by default) and a non-zero `wrData` whose set bits are contiguous stores `wrData` as the mask of COS n.
- R3: A write whose data is zero or has more than one run of set bits is rejected. The stored mask stays unchanged and `wrErr` is high in the cycle after the write.
- R4: A write to an address below BASE_ADDR or at or above BASE_ADDR + NUM_COS changes no mask and raises `wrErr` in the cycle after the write.
- R5: When `assocWrEn` is high, the association register of thread `assocThread` takes `assocCos` (6 bits, values 0 to 63).
- R6: `lookupMask` and `lookupCos` are registered. After each clock edge they give the mask and COS of thread `curThread`, and they already include any mask write or association write made at that same edge.
- R7: If the current thread's COS is NUM_COS or larger, `lookupMask` is all ones.
- R8: `wrErr` is low in every cycle that does not follow a rejected write. It is never high after a cycle without `wrEn`.
- R9: A mask write to one COS leaves the masks of all other COS values unchanged.
- R10: `lookupCos` carries the current thread's COS in the same cycle as the matching `lookupMask`, so that a sibling table can use the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Mask write strobe |
| wrAddr | input | ADDR_W (12) | Mask register address |
| wrData | input | MASK_W (8) | Mask value to write |
| assocWrEn | input | 1 | Association register write strobe |
| assocThread | input | TID_W (1) | Thread whose association register is written |
| assocCos | input | 6 | COS value for the association write |
| curThread | input | TID_W (1) | Thread that is currently running |
| lookupMask | output | MASK_W (8) | Registered way-enable mask of the running thread |
| lookupCos | output | 6 | Registered COS of the running thread |
| wrErr | output | 1 | One-cycle pulse after a rejected or out-of-window mask write |

## Verification
The mask writes include masks that are valid at the low end, in the middle, at the top and across the full width. They also include a zero mask and a mask with a gap, which must be told apart from a real update. The error flag has to drop again after one cycle. Address checks cover the cell just below the base, the first cell above the last implemented class, and a cell far into the 64-entry window. Association writes switch a thread between classes that exist, the first class beyond the table, and the largest encodable class. A write that lands in the same cycle as a lookup must show up in that lookup. Switching `curThread` must show that each thread keeps its own COS.

// File: rtl/cosMaskPkg.sv
package cosMaskPkg;
  // COS index width: the association field can name up to 64 classes
  localparam int COS_IDX_W = 6;

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic                 tableWr;
    logic [COS_IDX_W-1:0] tableIdx;
    logic                 errPulse;
  } ctrlStrobe_t;
endpackage

// File: rtl/cosMaskCtrl.sv
module cosMaskCtrl
  import cosMaskPkg::*;
#(
  parameter int MASK_W    = 8,
  parameter int NUM_COS   = 4,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'hD10
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [MASK_W-1:0] wrData,
  output ctrlStrobe_t       strobe
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] LIMIT_V = ADDR_W'(NUM_COS);

  logic [MASK_W:0]   dataExt;
  logic [MASK_W:0]   fillLow;
  logic [MASK_W:0]   fillInc;
  logic              isContig;
  logic [ADDR_W-1:0] offset;
  logic              inWindow;

  always_comb begin
    // Set every bit below the lowest one, then the +1 carry must clear it all
    dataExt  = {1'b0, wrData};
    fillLow  = dataExt | (dataExt - 1'b1);
    fillInc  = fillLow + 1'b1;
    isContig = (wrData != '0) && ((fillLow & fillInc) == '0);

    offset   = wrAddr - BASE_V;
    inWindow = (wrAddr >= BASE_V) && (offset < LIMIT_V);

    strobe.tableWr  = wrEn && inWindow && isContig;
    strobe.tableIdx = offset[COS_IDX_W-1:0];
    strobe.errPulse = wrEn && !(inWindow && isContig);
  end
endmodule

// File: rtl/cosMaskDatapath.sv
module cosMaskDatapath
  import cosMaskPkg::*;
#(
  parameter int MASK_W      = 8,
  parameter int NUM_COS     = 4,
  parameter int NUM_THREADS = 2,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int IDX_W      = (NUM_COS > 1) ? $clog2(NUM_COS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [MASK_W-1:0]    wrData,
  input  logic                 assocWrEn,
  input  logic [TID_W-1:0]     assocThread,
  input  logic [COS_IDX_W-1:0] assocCos,
  input  logic [TID_W-1:0]     curThread,
  output logic [MASK_W-1:0]    lookupMask,
  output logic [COS_IDX_W-1:0] lookupCos,
  output logic                 wrErr
);
  logic [MASK_W-1:0]    maskTable [NUM_COS];
  logic [COS_IDX_W-1:0] threadCos [NUM_THREADS];
  logic [COS_IDX_W-1:0] nextCos;
  logic [MASK_W-1:0]    nextMask;

  for (genvar c = 0; c < NUM_COS; c++) begin : g_maskEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskTable[c] <= '1;
      end else if (strobe.tableWr && (strobe.tableIdx == COS_IDX_W'(c))) begin
        maskTable[c] <= wrData;
      end
    end
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_assocReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        threadCos[t] <= '0;
      end else if (assocWrEn && (assocThread == TID_W'(t))) begin
        threadCos[t] <= assocCos;
      end
    end
  end

  // Bypass same-edge writes so the registered lookup is current
  always_comb begin
    if (assocWrEn && (assocThread == curThread)) begin
      nextCos = assocCos;
    end else begin
      nextCos = threadCos[curThread];
    end

    if (nextCos >= COS_IDX_W'(NUM_COS)) begin
      nextMask = '1;
    end else if (strobe.tableWr && (strobe.tableIdx == nextCos)) begin
      nextMask = wrData;
    end else begin
      nextMask = maskTable[nextCos[IDX_W-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lookupMask <= '1;
      lookupCos  <= '0;
      wrErr      <= 1'b0;
    end else begin
      lookupMask <= nextMask;
      lookupCos  <= nextCos;
      wrErr      <= strobe.errPulse;
    end
  end
endmodule

// File: rtl/cosMaskTable.sv
module cosMaskTable
  import cosMaskPkg::*;
#(
  parameter int MASK_W      = 8,
  parameter int NUM_COS     = 4,
  parameter int NUM_THREADS = 2,
  parameter int ADDR_W      = 12,
  parameter int BASE_ADDR   = 'hD10,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [MASK_W-1:0]    wrData,
  input  logic                 assocWrEn,
  input  logic [TID_W-1:0]     assocThread,
  input  logic [COS_IDX_W-1:0] assocCos,
  input  logic [TID_W-1:0]     curThread,
  output logic [MASK_W-1:0]    lookupMask,
  output logic [COS_IDX_W-1:0] lookupCos,
  output logic                 wrErr
);
  ctrlStrobe_t strobe;

  cosMaskCtrl #(
    .MASK_W(MASK_W), .NUM_COS(NUM_COS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) ctrl_i (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .strobe(strobe)
  );

  cosMaskDatapath #(
    .MASK_W(MASK_W), .NUM_COS(NUM_COS), .NUM_THREADS(NUM_THREADS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .assocWrEn(assocWrEn), .assocThread(assocThread), .assocCos(assocCos),
    .curThread(curThread), .lookupMask(lookupMask), .lookupCos(lookupCos),
    .wrErr(wrErr)
  );
endmodule

// File: rtl/cosMaskTableChk.sv
module cosMaskTableChk
  import cosMaskPkg::*;
#(
  parameter int MASK_W    = 8,
  parameter int NUM_COS   = 4,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'hD10,
  parameter int TID_W     = 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    wrAddr,
  input logic [MASK_W-1:0]    wrData,
  input logic                 assocWrEn,
  input logic [TID_W-1:0]     curThread,
  input logic [MASK_W-1:0]    lookupMask,
  input logic [COS_IDX_W-1:0] lookupCos,
  input logic                 wrErr
);
  localparam int LIMIT = BASE_ADDR + NUM_COS;

  logic            outOfWindow;
  logic [MASK_W:0] outExt;
  logic [MASK_W:0] outFill;
  logic            outContig;

  always_comb begin
    outOfWindow = (int'(wrAddr) < BASE_ADDR) || (int'(wrAddr) >= LIMIT);
    outExt      = {1'b0, lookupMask};
    outFill     = outExt | (outExt - 1'b1);
    outContig   = (lookupMask != '0) && ((outFill & (outFill + 1'b1)) == '0);
  end

  AST_RESET_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (lookupMask == '1) && (lookupCos == '0) && !wrErr); // R1

  AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (!rstN)
    outContig); // R2

  AST_ZERO_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrData == '0)) |=> wrErr); // R3

  AST_WINDOW_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && outOfWindow) |=> wrErr); // R4

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !assocWrEn && $stable(curThread)) |=> ($stable(lookupMask) && $stable(lookupCos))); // R6

  AST_BEYOND_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (int'(lookupCos) >= NUM_COS) |-> (lookupMask == '1)); // R7

  AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !wrErr); // R8
endmodule

bind cosMaskTable cosMaskTableChk #(
  .MASK_W(MASK_W), .NUM_COS(NUM_COS), .ADDR_W(ADDR_W),
  .BASE_ADDR(BASE_ADDR), .TID_W(TID_W)
) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .assocWrEn(assocWrEn), .curThread(curThread), .lookupMask(lookupMask),
  .lookupCos(lookupCos), .wrErr(wrErr)
);

// File: tb/cosMaskTable_tb_top.sv
module cosMaskTable_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [11:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       assocWrEn = 1'b0;
  logic [0:0] assocThread = '0;
  logic [5:0] assocCos = '0;
  logic [0:0] curThread = '0;
  logic [7:0] lookupMask;
  logic [5:0] lookupCos;
  logic       wrErr;

  int applied = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cosMaskTable dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .assocWrEn(assocWrEn), .assocThread(assocThread), .assocCos(assocCos),
    .curThread(curThread), .lookupMask(lookupMask), .lookupCos(lookupCos),
    .wrErr(wrErr)
  );

  // kind: 0 idle, 1 mask write (addr, data), 2 assoc write (addr[0] thread, data[5:0] cos)
  typedef struct packed {
    logic [1:0]  kind;
    logic [11:0] addr;
    logic [7:0]  data;
    logic        cur;
    logic [7:0]  expMask;
    logic [5:0]  expCos;
    logic        expErr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 12'h000, 8'h00, 1'b0, 8'hFF, 6'd0,  1'b0, 4'd1},  // R1 idle after reset
    '{2'd1, 12'hD10, 8'h3C, 1'b0, 8'h3C, 6'd0,  1'b0, 4'd2},  // R2 middle run
    '{2'd1, 12'hD11, 8'h0F, 1'b0, 8'h3C, 6'd0,  1'b0, 4'd9},  // R9 other cos untouched
    '{2'd2, 12'h000, 8'h01, 1'b0, 8'h0F, 6'd1,  1'b0, 4'd5},  // R5 thread0 -> cos1
    '{2'd1, 12'hD11, 8'h0A, 1'b0, 8'h0F, 6'd1,  1'b1, 4'd3},  // R3 gapped mask
    '{2'd0, 12'h000, 8'h00, 1'b0, 8'h0F, 6'd1,  1'b0, 4'd8},  // R8 pulse drops
    '{2'd1, 12'hD11, 8'h00, 1'b0, 8'h0F, 6'd1,  1'b1, 4'd3},  // R3 zero mask
    '{2'd1, 12'hD14, 8'h01, 1'b0, 8'h0F, 6'd1,  1'b1, 4'd4},  // R4 first beyond
    '{2'd1, 12'hD0F, 8'h01, 1'b0, 8'h0F, 6'd1,  1'b1, 4'd4},  // R4 below base
    '{2'd2, 12'h001, 8'h09, 1'b1, 8'hFF, 6'd9,  1'b0, 4'd7},  // R7 thread1 cos9
    '{2'd0, 12'h000, 8'h00, 1'b0, 8'h0F, 6'd1,  1'b0, 4'd5},  // R5 thread0 kept cos1
    '{2'd1, 12'hD13, 8'h80, 1'b0, 8'h0F, 6'd1,  1'b0, 4'd9},  // R9 write cos3
    '{2'd2, 12'h000, 8'h03, 1'b0, 8'h80, 6'd3,  1'b0, 4'd6},  // R6 assoc bypass
    '{2'd1, 12'hD13, 8'hC0, 1'b0, 8'hC0, 6'd3,  1'b0, 4'd6},  // R6 mask bypass
    '{2'd2, 12'h001, 8'h3F, 1'b1, 8'hFF, 6'd63, 1'b0, 4'd7},  // R7 largest cos
    '{2'd2, 12'h001, 8'h04, 1'b1, 8'hFF, 6'd4,  1'b0, 4'd7},  // R7 cos == NUM_COS
    '{2'd2, 12'h001, 8'h00, 1'b1, 8'h3C, 6'd0,  1'b0, 4'd10}, // R10 cos follows mask
    '{2'd1, 12'hD10, 8'hFF, 1'b1, 8'hFF, 6'd0,  1'b0, 4'd2},  // R2 full width
    '{2'd1, 12'hD12, 8'h01, 1'b1, 8'hFF, 6'd0,  1'b0, 4'd2},  // R2 lowest bit
    '{2'd2, 12'h001, 8'h02, 1'b1, 8'h01, 6'd2,  1'b0, 4'd10}, // R10 cos2
    '{2'd1, 12'hD4F, 8'h01, 1'b1, 8'h01, 6'd2,  1'b1, 4'd4},  // R4 far in window
    '{2'd1, 12'hD12, 8'hFE, 1'b1, 8'hFE, 6'd2,  1'b0, 4'd2}   // R2 run to msb
  };

  task automatic check(input logic [7:0] eMask, input logic [5:0] eCos,
                       input logic eErr, input int req);
    applied++;
    if (lookupMask !== eMask || lookupCos !== eCos || wrErr !== eErr) begin
      errors++;
      $display("FAIL R%0d: mask=%h cos=%0d err=%b expected mask=%h cos=%0d err=%b",
               req, lookupMask, lookupCos, wrErr, eMask, eCos, eErr);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(8'hFF, 6'd0, 1'b0, 1);  // R1 during reset
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      wrEn      = (VECS[i].kind == 2'd1);
      assocWrEn = (VECS[i].kind == 2'd2);
      wrAddr    = VECS[i].addr;
      wrData    = VECS[i].data;
      assocThread = VECS[i].addr[0];
      assocCos  = VECS[i].data[5:0];
      curThread = VECS[i].cur;
      @(negedge clk);
      check(VECS[i].expMask, VECS[i].expCos, VECS[i].expErr, int'(VECS[i].req));
    end
    wrEn = 1'b0;
    assocWrEn = 1'b0;

    // R1: reset in mid-run reopens the masks and clears associations
    curThread = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    check(8'hFF, 6'd0, 1'b0, 1);
    rstN = 1'b1;
    assocWrEn = 1'b1; assocThread = 1'b0; assocCos = 6'd3;
    @(negedge clk);
    check(8'hFF, 6'd3, 1'b0, 1);  // R1 cos3 mask back to all ones
    assocWrEn = 1'b0;
    curThread = 1'b1;
    @(negedge clk);
    check(8'hFF, 6'd0, 1'b0, 1);  // R1 thread1 back at cos0

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL R6: watchdog expired, actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end
endmodule